// File: doc/BRIEF.md
# Unused Opcode NOP Sequencer

This block sits beside the instruction decoder of an 8-bit processor core with a 16-bit program counter. When the fetch stage presents an opcode that the instruction set leaves undefined, the block runs it as a no-operation. Each such opcode has a fixed byte length and a fixed cycle cost. Program flow and timing therefore stay deterministic, and no trap is raised. The block computes where the next instruction starts. It holds the core busy for the opcode's cost and then pulses completion. No architectural register, flag or memory location is touched.

An opcode is offered with `op_valid`, together with the address of its opcode byte on `pc_in`. If the block is idle and the opcode is one of the unused ones, it takes the opcode in that cycle. That acceptance cycle counts as the first cycle of the cost. Any other opcode causes a one-cycle `not_handled` pulse, and the block stays idle so the regular decoder can claim it. The stop instruction and all defined instructions are left to the rest of the core.

Top module: `unop_sequencer`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `not_handled` are 0, and `pc_next` and `pc_step` are 0.
- R2: Every opcode whose low nibble is 0x3 or 0xB is accepted as a 1-byte, 1-cycle no-operation.
- R3: The opcodes 0x02, 0x22, 0x42, 0x62, 0x82, 0xC2 and 0xE2 are accepted as 2-byte, 2-cycle no-operations. 0xA2 is not among them.
- R4: Opcode 0x44 is accepted as a 2-byte, 3-cycle no-operation.
- R5: Opcodes 0x54, 0xD4 and 0xF4 are accepted as 2-byte, 4-cycle no-operations.
- R6: Opcodes 0xDC and 0xFC are accepted as 3-byte, 4-cycle no-operations.
- R7: Opcode 0x5C is accepted as a 3-byte, 8-cycle no-operation.
- R8: In the `done` cycle, `pc_step` equals the byte length (1, 2 or 3). In the same cycle, `pc_next` equals `pc_in` plus that length modulo 2^16, so 0xFFFF plus 1 gives 0x0000. Both values hold until the next acceptance.
- R9: For an opcode costing N cycles, accepted at clock edge k, `busy` is high for exactly the N-1 cycles that follow edge k. `done` is then high for exactly one cycle, the cycle after edge k+N-1. `done` is never high together with `busy`.
- R10: An opcode outside the unused set, offered while idle, gives `not_handled` high for the one cycle after the edge. It leaves `busy` and `done` low and leaves `pc_next` unchanged.
- R11: `op_valid` is ignored while `busy` is high. The running operation's duration and `pc_next` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A fetched opcode is offered this cycle |
| op_code | input | 8 | The offered opcode byte |
| pc_in | input | 16 | Address of the offered opcode byte |
| busy | output | 1 | A no-operation is consuming its extra cycles |
| done | output | 1 | One-cycle pulse ending a no-operation |
| not_handled | output | 1 | One-cycle pulse: the offered opcode is not an unused one |
| pc_next | output | 16 | Address of the instruction after the no-operation |
| pc_step | output | 2 | Byte length of the last accepted no-operation |

## Verification
The bench builds the block with its default parameters: a 16-bit address width and a 4-bit cycle counter. The 16-bit width lets directed cases place 1-, 2- and 3-byte opcodes at 0xFFFE and 0xFFFF and observe the wrap of the next address directly. The 4-bit counter covers the 8-cycle class with margin, so every class's exact busy length is measured against its cost. A full sweep of all 256 opcodes checks that each one is classified correctly. The sweep is followed by random opcodes at random addresses, and by offers made while the block is busy.

// File: rtl/unop_pkg.sv
package unop_pkg;

    localparam int OP_W   = 8;
    localparam int LEN_W  = 2;
    localparam int CYC_W  = 4;

    // Class of an unused opcode: byte length and cycle cost per class.
    typedef enum logic [2:0] {
        K_NONE,
        K_L1_C1,
        K_L2_C2,
        K_L2_C3,
        K_L2_C4,
        K_L3_C4,
        K_L3_C8
    } nop_kind_e;

    typedef struct packed {
        logic              hit;
        logic [LEN_W-1:0]  len;
        logic [CYC_W-1:0]  cyc;
        nop_kind_e         kind;
    } nop_attr_t;

    function automatic nop_kind_e kind_of(input logic [OP_W-1:0] op);
        nop_kind_e k;
        logic [3:0] lo;
        logic [3:0] hi;
        lo = op[3:0];
        hi = op[7:4];
        k  = K_NONE;
        if (lo == 4'h3 || lo == 4'hB) begin
            k = K_L1_C1;
        end else if (lo == 4'h2) begin
            // even high nibble, excluding the load-immediate slot at 0xA
            if (!hi[0] && hi != 4'hA) k = K_L2_C2;
        end else if (lo == 4'h4) begin
            case (hi)
                4'h4:                k = K_L2_C3;
                4'h5, 4'hD, 4'hF:    k = K_L2_C4;
                default:             k = K_NONE;
            endcase
        end else if (lo == 4'hC) begin
            case (hi)
                4'h5:                k = K_L3_C8;
                4'hD, 4'hF:          k = K_L3_C4;
                default:             k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic nop_attr_t attr_of(input nop_kind_e k);
        nop_attr_t a;
        a.kind = k;
        a.hit  = (k != K_NONE);
        unique case (k)
            K_L1_C1: begin a.len = 2'd1; a.cyc = 4'd1; end
            K_L2_C2: begin a.len = 2'd2; a.cyc = 4'd2; end
            K_L2_C3: begin a.len = 2'd2; a.cyc = 4'd3; end
            K_L2_C4: begin a.len = 2'd2; a.cyc = 4'd4; end
            K_L3_C4: begin a.len = 2'd3; a.cyc = 4'd4; end
            K_L3_C8: begin a.len = 2'd3; a.cyc = 4'd8; end
            default: begin a.len = 2'd0; a.cyc = 4'd0; end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/unop_classify.sv
module unop_classify
    import unop_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output nop_attr_t       attr
);

    always_comb begin
        attr = attr_of(kind_of(op_code));
    end

endmodule

// File: rtl/unop_timer.sv
module unop_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cycles,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] left_q;
    logic             busy_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                if (cycles <= ONE) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    left_q <= cycles - ONE;
                end
            end else if (busy_q) begin
                if (left_q == ONE) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
                left_q <= left_q - ONE;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/unop_pc_adv.sv
module unop_pc_adv #(
    parameter int PC_W  = 16,
    parameter int LEN_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [LEN_W-1:0] len,
    output logic [PC_W-1:0]  pc_next,
    output logic [LEN_W-1:0] pc_step
);

    logic [PC_W-1:0]  sum;
    logic [PC_W-1:0]  pc_q;
    logic [LEN_W-1:0] step_q;

    // modular add: the carry out of the top bit is dropped
    assign sum = pc_in + PC_W'(len);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            step_q <= '0;
        end else if (load) begin
            pc_q   <= sum;
            step_q <= len;
        end
    end

    assign pc_next = pc_q;
    assign pc_step = step_q;

endmodule

// File: rtl/unop_sequencer.sv
module unop_sequencer
    import unop_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = CYC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic [PC_W-1:0]  pc_in,
    output logic             busy,
    output logic             done,
    output logic             not_handled,
    output logic [PC_W-1:0]  pc_next,
    output logic [1:0]       pc_step
);

    nop_attr_t attr;
    logic      idle_offer;
    logic      take;
    logic      refuse;
    logic      nh_q;

    unop_classify u_cls (
        .op_code (op_code),
        .attr    (attr)
    );

    assign idle_offer = op_valid && !busy;
    assign take       = idle_offer && attr.hit;
    assign refuse     = idle_offer && !attr.hit;

    unop_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (take),
        .cycles (CNT_W'(attr.cyc)),
        .busy   (busy),
        .done   (done)
    );

    unop_pc_adv #(.PC_W(PC_W), .LEN_W(LEN_W)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .load    (take),
        .pc_in   (pc_in),
        .len     (attr.len),
        .pc_next (pc_next),
        .pc_step (pc_step)
    );

    always_ff @(posedge clk) begin
        if (rst) nh_q <= 1'b0;
        else     nh_q <= refuse;
    end

    assign not_handled = nh_q;

endmodule

// File: rtl/unop_sequencer_chk.sv
module unop_sequencer_chk #(
    parameter int PC_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            not_handled,
    input logic [PC_W-1:0] pc_next,
    input logic [1:0]      pc_step
);

    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 4'd1;
        else           run_q <= '0;
    end

    AST_DONE_ENDS_BUSY:    assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R9
    AST_NO_DONE_IN_BUSY:   assert property (@(posedge clk) disable iff (rst) busy |-> !done); // R9
    AST_BUSY_RUN_LIMIT:    assert property (@(posedge clk) disable iff (rst) run_q <= 4'd7); // R7
    AST_REFUSE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst) not_handled |-> (!busy && !done)); // R10
    AST_BUSY_HOLDS_PC:     assert property (@(posedge clk) disable iff (rst) busy |=> $stable(pc_next)); // R11
    AST_STEP_IN_RANGE:     assert property (@(posedge clk) disable iff (rst) done |-> (pc_step != 2'd0)); // R8

endmodule

bind unop_sequencer unop_sequencer_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .not_handled (not_handled),
    .pc_next     (pc_next),
    .pc_step     (pc_step)
);

// File: tb/unop_sequencer_tb.sv
`timescale 1ns/1ps
module unop_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [7:0]  op_code;
    logic [15:0] pc_in;
    logic        busy, done, not_handled;
    logic [15:0] pc_next;
    logic [1:0]  pc_step;

    int tests = 0;
    int fails = 0;
    logic [15:0] last_pc;

    always #2.5 clk = ~clk;

    unop_sequencer u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .pc_in(pc_in), .busy(busy), .done(done), .not_handled(not_handled),
        .pc_next(pc_next), .pc_step(pc_step)
    );

    // expected byte length and cycle cost, 0/0 when the opcode is defined
    function automatic void ref_nop(input logic [7:0] op, output int len, output int cyc, output string tag);
        len = 0; cyc = 0; tag = "R10";
        if (op[3:0] == 4'h3 || op[3:0] == 4'hB) begin len = 1; cyc = 1; tag = "R2"; end
        else case (op)
            8'h02, 8'h22, 8'h42, 8'h62, 8'h82, 8'hC2, 8'hE2: begin len = 2; cyc = 2; tag = "R3"; end
            8'h44:                begin len = 2; cyc = 3; tag = "R4"; end
            8'h54, 8'hD4, 8'hF4:  begin len = 2; cyc = 4; tag = "R5"; end
            8'hDC, 8'hFC:         begin len = 3; cyc = 4; tag = "R6"; end
            8'h5C:                begin len = 3; cyc = 8; tag = "R7"; end
            default: ;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] pc, input bit poke);
        int len, cyc, busy_n, done_at, late_done;
        logic [15:0] got_pc, exp_pc;
        logic [1:0]  got_step;
        string tag;
        ref_nop(op, len, cyc, tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; pc_in = pc;
        @(posedge clk);
        if (cyc == 0) begin
            @(negedge clk);
            op_valid = 1'b0;
            check(not_handled && !busy && !done, "R10", "refused opcode flags", {not_handled, busy, done}, 3'b100);
            check(pc_next == last_pc, "R10", "pc_next after refusal", pc_next, last_pc);
            @(negedge clk);
            check(!not_handled, "R10", "not_handled pulse width", not_handled, 0);
            return;
        end
        busy_n = 0; done_at = 0; late_done = 0; got_pc = '0; got_step = '0;
        for (int i = 1; i <= cyc + 1; i++) begin
            @(negedge clk);
            if (i == 1) begin
                if (poke && cyc >= 2) begin
                    op_code = 8'h03; pc_in = 16'h1234;   // R11: offered while busy
                end else begin
                    op_valid = 1'b0;
                end
            end
            if (i == 2) op_valid = 1'b0;
            if (busy) busy_n++;
            if (done && done_at == 0) begin
                done_at = i; got_pc = pc_next; got_step = pc_step;
            end else if (done) begin
                late_done = i;
            end
        end
        exp_pc = pc + 16'(len);
        check(busy_n == cyc - 1, tag, "busy cycle count (R9)", busy_n, cyc - 1);
        check(done_at == cyc, tag, "done cycle (R9)", done_at, cyc);
        check(late_done == 0, "R9", "done longer than one cycle", late_done, 0);
        check(got_pc == exp_pc, "R8", "pc_next", got_pc, exp_pc);
        check(int'(got_step) == len, "R8", "pc_step", got_step, len);
        if (poke) check(pc_next == exp_pc, "R11", "pc_next after busy offer", pc_next, exp_pc);
        last_pc = exp_pc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        rst = 1'b1; op_valid = 1'b0; op_code = '0; pc_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done && !not_handled, "R1", "reset flags", {busy, done, not_handled}, 0);
        check(pc_next == 16'h0 && pc_step == 2'd0, "R1", "reset pc_next/pc_step", pc_next, 0);
        rst = 1'b0;
        last_pc = 16'h0;

        // directed wrap cases (R8)
        run_op(8'h03, 16'hFFFF, 1'b0);
        run_op(8'h5C, 16'hFFFE, 1'b0);
        run_op(8'hDC, 16'hFFFF, 1'b0);
        run_op(8'h42, 16'hFFFF, 1'b0);
        run_op(8'hA2, 16'h0100, 1'b0);   // R3/R10: load-immediate slot refused

        // full opcode sweep
        for (int op = 0; op < 256; op++) begin
            run_op(8'(op), 16'($urandom), 1'b0);
        end

        // offers while busy (R11)
        run_op(8'h5C, 16'h2000, 1'b1);
        run_op(8'h44, 16'h3000, 1'b1);
        run_op(8'hFC, 16'hFFFE, 1'b1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            run_op(8'($urandom), 16'($urandom), 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule